// File: doc/BRIEF.md
# SPI Master Shift Engine with Programmable SDO Idle Level

This block is a single-slave SPI master. It accepts one command at a time: drive the chip select active, drive it inactive, shift a word out, shift a word in, or do both at once. Write data arrives on a valid/ready TX port and captured words leave on a valid/ready RX port. SCLK is the system clock divided by a fixed parameter. Clock polarity and phase come from a small host configuration register.

The data output has a programmable rest level. One configuration bit sets the level that SDO holds whenever it is not carrying write data. That covers the time the chip select is inactive, every bit of a read-only command, and the moment after a write ends. The line does not keep the last bit it shifted. This lets a slave that reads its input as a control signal between frames, for example a converter that wants its input high while it converts, share the bus with ordinary register writes. The feature is always built in. With the bit cleared, which is the reset value, SDO rests low.

A configuration write takes effect only while the engine has no transfer in progress. A write issued during a transfer is held and applied once the engine is idle again.

Top module: `spi_idle_ctrl`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, spi_sdo is 0, rx_valid is 0 and cmd_ready is 1.
- R2: Configuration bit 3 is the SDO rest level. Whenever spi_cs_n is 1, spi_sdo equals that level, even while a write command is shifting.
- R3: During a read command (op 3), spi_sdo holds the rest level for the whole transfer.
- R4: When a write or write-and-read ends, spi_sdo returns to the rest level DIV/2 clock cycles after the final sampling edge, whatever the last data bit was.
- R5: Configuration bit 0 is CPOL and bit 1 is CPHA. SCLK rests at CPOL, each half period lasts DIV/2 clocks, and data is sampled on the leading edge when CPHA=0 and on the trailing edge when CPHA=1.
- R6: cmd_len holds the bit count minus one (1 to DATA_W bits). A write sends the low bits of the TX word, most significant first, and SDO changes only at bit boundaries.
- R7: A write-and-read (op 4) or read (op 3) returns the SDI bits right-aligned in rx_data. rx_valid rises DIV/2 clock cycles after the final sampling edge.
- R8: While rx_valid is 1 and rx_ready is 0, rx_valid and rx_data hold steady and no new command is accepted.
- R9: A configuration write made during a transfer does not change SCLK or SDO until that transfer has finished.
- R10: Op codes: 0 drives CS active, 1 drives CS inactive, 2 write, 3 read, 4 write-and-read. Codes 5 to 7 are accepted and have no effect, and a shifting command drops cmd_ready until it has finished.
- R11: A write or write-and-read waits with tx_ready at 1 and SCLK at rest until a TX word is supplied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration value (bit 0 CPOL, bit 1 CPHA, bit 3 SDO rest level) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 3 | Command op code |
| cmd_len | input | LEN_W | Bit count minus one |
| tx_valid | input | 1 | TX word offered |
| tx_ready | output | 1 | Engine waits for a TX word |
| tx_data | input | DATA_W | TX word, right-aligned |
| rx_valid | output | 1 | Captured word available |
| rx_ready | input | 1 | Consumer takes the RX word |
| rx_data | output | DATA_W | Captured word, right-aligned |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sdo | output | 1 | Serial data out |
| spi_sdi | input | 1 | Serial data in |

## Verification
The assertions assume that cmd_op, cmd_len and tx_data are stable while a handshake is pending, and that SDI changes only away from the sampling clock edge. The bench drives every input on the falling system clock edge. Its slave model moves SDI half a system cycle after each sampling edge, and it holds valid until the matching ready has been seen. The bench writes the configuration register mid-transfer only in the one test that exercises the deferral.

// File: rtl/spi_idle_pkg.sv
// Shared types for the SPI master shift engine.
// Assumes: the configuration field positions below are fixed by the host software.
package spi_idle_pkg;

    typedef enum logic [2:0] {
        OP_CS_ON  = 3'd0,
        OP_CS_OFF = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_XFER   = 3'd4
    } spi_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_TX,
        ST_SHIFT,
        ST_RX_OUT
    } eng_state_e;

    typedef struct packed {
        logic idle_hi;
        logic cpha;
        logic cpol;
    } spi_mode_t;

    localparam int CFG_CPOL_BIT = 0;
    localparam int CFG_CPHA_BIT = 1;
    localparam int CFG_IDLE_BIT = 3;

endpackage

// File: rtl/spi_idle_cfg.sv
// Configuration holder. Keeps a staged copy of each host write and an active
// copy that the shift logic uses. The active copy follows the staged one only
// while hold is low, so a mode change never lands inside a transfer.
// Assumes: CFG_W is larger than the highest field bit.
module spi_idle_cfg
    import spi_idle_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             hold,
    output spi_mode_t        mode_o
);

    spi_mode_t staged_q;
    spi_mode_t decoded;
    logic      unused_cfg_bits;

    assign decoded.idle_hi = wr_data[CFG_IDLE_BIT];
    assign decoded.cpha    = wr_data[CFG_CPHA_BIT];
    assign decoded.cpol    = wr_data[CFG_CPOL_BIT];
    assign unused_cfg_bits = ^wr_data;

    // Capture every host write into the staged copy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            staged_q <= '0;
        else if (wr_en)
            staged_q <= decoded;
    end

    // Move the staged value into use only while no transfer is running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_o <= '0;
        else if (!hold)
            mode_o <= wr_en ? decoded : staged_q;
    end

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(mode_o));

endmodule

// File: rtl/spi_idle_timer.sv
// Half-period tick source. While run is high, tick pulses once every HALF
// system clocks. The count restarts whenever run is low.
// Assumes: HALF >= 1. HALF == 1 needs no counter.
module spi_idle_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (HALF <= 1) begin : g_every
            logic unused_in;
            assign unused_in = clk ^ rst_n;
            assign tick      = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF);
            logic [CW-1:0] cnt_q;

            assign tick = run && (cnt_q == CW'(HALF - 1));

            // Count system clocks within one half SCLK period.
            always_ff @(posedge clk) begin
                if (!rst_n || !run)
                    cnt_q <= '0;
                else if (tick)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assert_half_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/spi_idle_shifter.sv
// Data path. Holds the outgoing word MSB-aligned, shifts it left one place per
// bit and collects incoming bits right-aligned. last_bit flags the final bit.
// Assumes: load, sample and advance are never high in the same cycle.
module spi_idle_shifter #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              sample,
    input  logic              advance,
    input  logic              sdi,
    output logic              tx_msb,
    output logic [DATA_W-1:0] rx_word,
    output logic              last_bit
);

    logic [DATA_W-1:0] tx_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;

    assign tx_msb   = tx_q[DATA_W-1];
    assign last_bit = (idx_q == len_q);

    // Align the outgoing word so its first bit sits at the top, then shift it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_q <= '0;
        else if (load)
            tx_q <= load_word << (LEN_W'(DATA_W - 1) - load_len);
        else if (advance)
            tx_q <= tx_q << 1;
    end

    // Collect SDI bits at the sampling points.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_word <= '0;
        else if (load)
            rx_word <= '0;
        else if (sample)
            rx_word <= {rx_word[DATA_W-2:0], sdi};
    end

    // Track which bit of the word is on the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            len_q <= '0;
        end else if (load) begin
            idx_q <= '0;
            len_q <= load_len;
        end else if (advance && !last_bit) begin
            idx_q <= idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_idle_ctrl.sv
// SPI master shift engine with a programmable SDO rest level. It takes one
// command at a time and runs a four-state sequencer (idle, wait for TX word,
// shift, present RX word). Each bit has two half periods: SDO changes when a
// bit starts and SDI is sampled between the halves. SCLK is derived from the
// half index and the active mode. SDO carries data only while a write is
// shifting with CS active. Otherwise it sits at the configured rest level.
// Assumes: handshake inputs are stable while their valid is high. DIV >= 2.
module spi_idle_ctrl
    import spi_idle_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int DIV    = 4,
    parameter  int CFG_W  = 8,
    localparam int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_sdo,
    input  logic              spi_sdi
);

    localparam int HALF = (DIV / 2 < 1) ? 1 : DIV / 2;

    eng_state_e        state_q;
    logic              cs_n_q;
    logic              h_q;
    logic              op_tx_q;
    logic              op_rx_q;
    logic [LEN_W-1:0]  len_q;
    spi_mode_t         mode;
    spi_op_e           op;
    logic              shifting;
    logic              tick;
    logic              sample;
    logic              advance;
    logic              last_bit;
    logic              tx_msb;
    logic              load;
    logic              cmd_fire;
    logic [DATA_W-1:0] load_word;
    logic [LEN_W-1:0]  load_len;

    assign op        = spi_op_e'(cmd_op);
    assign shifting  = (state_q == ST_SHIFT);
    assign cmd_ready = (state_q == ST_IDLE);
    assign tx_ready  = (state_q == ST_WAIT_TX);
    assign rx_valid  = (state_q == ST_RX_OUT);
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign sample    = tick && !h_q;
    assign advance   = tick && h_q;
    assign load      = (cmd_fire && op == OP_READ) || (tx_valid && tx_ready);
    assign load_word = tx_ready ? tx_data : '0;
    assign load_len  = tx_ready ? len_q : cmd_len;

    spi_idle_cfg #(.CFG_W(CFG_W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .hold    (!cmd_ready),
        .mode_o  (mode)
    );

    spi_idle_timer #(.HALF(HALF)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (shifting),
        .tick  (tick)
    );

    spi_idle_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .load_len  (load_len),
        .sample    (sample),
        .advance   (advance),
        .sdi       (spi_sdi),
        .tx_msb    (tx_msb),
        .rx_word   (rx_data),
        .last_bit  (last_bit)
    );

    // Sequence commands, chip select and the half-period index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
            h_q     <= 1'b0;
            op_tx_q <= 1'b0;
            op_rx_q <= 1'b0;
            len_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        case (op)
                            OP_CS_ON:  cs_n_q <= 1'b0;
                            OP_CS_OFF: cs_n_q <= 1'b1;
                            OP_WRITE: begin
                                op_tx_q <= 1'b1;
                                op_rx_q <= 1'b0;
                                len_q   <= cmd_len;
                                state_q <= ST_WAIT_TX;
                            end
                            OP_XFER: begin
                                op_tx_q <= 1'b1;
                                op_rx_q <= 1'b1;
                                len_q   <= cmd_len;
                                state_q <= ST_WAIT_TX;
                            end
                            OP_READ: begin
                                op_tx_q <= 1'b0;
                                op_rx_q <= 1'b1;
                                len_q   <= cmd_len;
                                state_q <= ST_SHIFT;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_WAIT_TX: begin
                    if (tx_valid)
                        state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (tick)
                        h_q <= ~h_q;
                    if (advance && last_bit)
                        state_q <= op_rx_q ? ST_RX_OUT : ST_IDLE;
                end
                ST_RX_OUT: begin
                    if (rx_ready)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the serial lines from the sequencer state and the active mode.
    always_comb begin
        spi_cs_n = cs_n_q;
        spi_sclk = mode.cpol ^ (shifting & (h_q ^ mode.cpha));
        spi_sdo  = (shifting && op_tx_q && !cs_n_q) ? tx_msb : mode.idle_hi;
    end

    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    assert_sdo_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && !(tick && h_q)) |=> $stable(spi_sdo));

    assert_read_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && !op_tx_q) |=> $stable(spi_sdo));

    assert_rest_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shifting) |-> (spi_sdo == mode.idle_hi));

    assert_cmd_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && (op == OP_WRITE || op == OP_READ || op == OP_XFER)) |=> !cmd_ready);

endmodule

// File: tb/spi_idle_ctrl_tb_top.sv
// Bench for the SPI master shift engine. It contains a slave model that
// rebuilds the SDO word from the SCLK edges and feeds SDI, a table of
// transfers walked by one loop, and directed tests for reset and corner cases.
module spi_idle_ctrl_tb_top;
    import spi_idle_pkg::*;

    localparam int DATA_W = 32;
    localparam int DIV    = 4;
    localparam int HALF   = DIV / 2;
    localparam int LEN_W  = $clog2(DATA_W);
    localparam int NVEC   = 8;

    typedef struct packed {
        logic        cpol;
        logic        cpha;
        logic        idle;
        logic [2:0]  op;
        logic [5:0]  bits;
        logic [31:0] tx;
        logic [31:0] slv;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 3'd2, 6'd8,  32'h0000_00A5, 32'h0000_0000},
        '{1'b0, 1'b0, 1'b1, 3'd2, 6'd8,  32'h0000_005A, 32'h0000_0000},
        '{1'b0, 1'b1, 1'b1, 3'd3, 6'd12, 32'h0000_0000, 32'h0000_0ABC},
        '{1'b1, 1'b0, 1'b0, 3'd4, 6'd16, 32'h0000_1234, 32'h0000_BEEF},
        '{1'b1, 1'b1, 1'b1, 3'd4, 6'd32, 32'hDEAD_BEE0, 32'h1357_2468},
        '{1'b0, 1'b0, 1'b1, 3'd4, 6'd1,  32'h0000_0000, 32'h0000_0001},
        '{1'b1, 1'b1, 1'b0, 3'd3, 6'd1,  32'h0000_0000, 32'h0000_0001},
        '{1'b1, 1'b0, 1'b1, 3'd2, 6'd5,  32'h0000_01F0, 32'h0000_0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [2:0]        cmd_op = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              tx_valid = 1'b0;
    logic              tx_ready;
    logic [DATA_W-1:0] tx_data = '0;
    logic              rx_valid;
    logic              rx_ready = 1'b0;
    logic [DATA_W-1:0] rx_data;
    logic              spi_sclk;
    logic              spi_cs_n;
    logic              spi_sdo;
    logic              spi_sdi;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic        exp_cpol = 1'b0;
    logic        exp_cpha = 1'b0;
    logic        exp_idle = 1'b0;
    logic        mon_en   = 1'b0;
    logic        mon_ro   = 1'b0;
    int          cur_bits = 1;
    logic [31:0] slave_word = '0;

    int          mon_cnt = 0;
    logic [31:0] mon_bits = '0;
    int          last_samp = 0;
    logic        prev_sclk = 1'b0;
    int          ro_err = 0;
    int          cs_err = 0;

    spi_idle_ctrl #(.DATA_W(DATA_W), .DIV(DIV), .CFG_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_len   (cmd_len),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .rx_data   (rx_data),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_sdo   (spi_sdo),
        .spi_sdi   (spi_sdi)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Slave model: record SDO on sampling edges and count rest-level violations.
    always @(negedge clk) begin
        if (!rst_n || spi_cs_n) begin
            mon_cnt  <= 0;
            mon_bits <= '0;
        end else if (spi_sclk != prev_sclk) begin
            if ((prev_sclk == exp_cpol) ^ exp_cpha) begin
                mon_bits  <= {mon_bits[30:0], spi_sdo};
                mon_cnt   <= mon_cnt + 1;
                last_samp <= cyc;
            end
        end
        prev_sclk <= spi_sclk;
        if (mon_ro && spi_sdo !== exp_idle)
            ro_err <= ro_err + 1;
        if (mon_en && spi_cs_n && spi_sdo !== exp_idle)
            cs_err <= cs_err + 1;
    end

    // Slave SDI: send the slave word MSB first, one bit per sampling edge.
    always_comb begin
        int k;
        k = cur_bits - 1 - mon_cnt;
        spi_sdi = (k >= 0 && k < 32) ? slave_word[k[4:0]] : 1'b0;
    end

    function automatic logic [31:0] mask_of(input int bits);
        return (bits >= 32) ? 32'hFFFF_FFFF : ((32'h1 << bits) - 32'h1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_cfg(input logic cpol, input logic cpha, input logic idle);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = {4'b0000, idle, 1'b0, cpha, cpol};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_cfg(input logic cpol, input logic cpha, input logic idle);
        put_cfg(cpol, cpha, idle);
        exp_cpol = cpol;
        exp_cpha = cpha;
        exp_idle = idle;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [2:0] op, input logic [LEN_W-1:0] len);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_len   = len;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push_tx(input logic [31:0] word);
        tx_valid = 1'b1;
        tx_data  = word;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic take_rx();
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        int ro0;
        int cs0;
        logic [31:0] held;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 cs_n", spi_cs_n, 1);
        chk("R1 sclk", spi_sclk, 0);
        chk("R1 sdo", spi_sdo, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 cmd_ready", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of transfers
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            set_cfg(v.cpol, v.cpha, v.idle);
            mon_en = 1'b1;
            chk("R2 rest level with CS inactive", spi_sdo, v.idle);
            chk("R5 SCLK rests at CPOL", spi_sclk, v.cpol);
            send_cmd(OP_CS_ON, '0);
            cur_bits   = v.bits;
            slave_word = v.slv;
            ro0        = ro_err;
            mon_ro     = (v.op == 3'd3);
            send_cmd(v.op, LEN_W'(v.bits - 1));
            if (v.op != 3'd3) push_tx(v.tx);
            if (v.op != 3'd2) begin
                while (!rx_valid) @(negedge clk);
                chk("R7 rx_valid delay", cyc - last_samp, HALF);
                chk("R7 rx word", rx_data, v.slv & mask_of(v.bits));
                chk("R4 rest level after last bit", spi_sdo, v.idle);
                take_rx();
            end else begin
                while (!cmd_ready) @(negedge clk);
                chk("R4 return delay", cyc - last_samp, HALF);
                chk("R4 rest level after write", spi_sdo, v.idle);
            end
            mon_ro = 1'b0;
            chk("R6 bit count", mon_cnt, v.bits);
            if (v.op != 3'd3)
                chk("R6 shifted word", mon_bits, v.tx & mask_of(v.bits));
            else
                chk("R3 SDO at rest during read", ro_err, ro0);
            send_cmd(OP_CS_OFF, '0);
            chk("R10 CS inactive", spi_cs_n, 1);
            chk("R2 rest level after CS off", spi_sdo, v.idle);
            mon_en = 1'b0;
        end

        // R9: configuration written mid-transfer is deferred
        set_cfg(1'b0, 1'b0, 1'b0);
        send_cmd(OP_CS_ON, '0);
        cur_bits   = 16;
        slave_word = 32'h0000_C3A5;
        ro0        = ro_err;
        mon_ro     = 1'b1;
        send_cmd(OP_READ, LEN_W'(15));
        repeat (6) @(negedge clk);
        put_cfg(1'b0, 1'b0, 1'b1);
        while (!rx_valid) @(negedge clk);
        chk("R9 SDO kept old level during transfer", ro_err, ro0);
        chk("R7 rx word after deferred cfg", rx_data, 32'h0000_C3A5);
        take_rx();
        mon_ro   = 1'b0;
        exp_idle = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 new level after transfer", spi_sdo, 1);
        send_cmd(OP_CS_OFF, '0);

        // R8: RX back-pressure
        send_cmd(OP_CS_ON, '0);
        cur_bits   = 8;
        slave_word = 32'h0000_0096;
        send_cmd(OP_XFER, LEN_W'(7));
        push_tx(32'h0000_003C);
        while (!rx_valid) @(negedge clk);
        held = rx_data;
        repeat (5) @(negedge clk);
        chk("R8 rx_valid held", rx_valid, 1);
        chk("R8 rx_data held", rx_data, held);
        chk("R8 rx_data value", rx_data, 32'h0000_0096);
        chk("R8 no command taken", cmd_ready, 0);
        take_rx();
        chk("R8 rx_valid drops after take", rx_valid, 0);
        send_cmd(OP_CS_OFF, '0);

        // R10: unused op code has no effect
        send_cmd(3'd6, '0);
        chk("R10 unused op keeps CS", spi_cs_n, 1);
        chk("R10 unused op keeps ready", cmd_ready, 1);
        chk("R10 unused op keeps SDO", spi_sdo, 1);
        chk("R11 tx_ready low when idle", tx_ready, 0);

        // R11: write stalls until a TX word arrives
        set_cfg(1'b0, 1'b0, 1'b0);
        send_cmd(OP_CS_ON, '0);
        cur_bits = 4;
        send_cmd(OP_WRITE, LEN_W'(3));
        repeat (10) @(negedge clk);
        chk("R11 tx_ready while waiting", tx_ready, 1);
        chk("R11 SCLK at rest while waiting", spi_sclk, 0);
        chk("R11 no bits while waiting", mon_cnt, 0);
        push_tx(32'h0000_000A);
        while (!cmd_ready) @(negedge clk);
        chk("R11 word after stall", mon_bits, 32'h0000_000A);
        send_cmd(OP_CS_OFF, '0);

        // R2: a write with CS inactive leaves SDO at the rest level
        set_cfg(1'b0, 1'b0, 1'b1);
        mon_en = 1'b1;
        cs0    = cs_err;
        send_cmd(OP_WRITE, LEN_W'(7));
        push_tx(32'h0000_0000);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        chk("R2 SDO at rest during write with CS off", cs_err, cs0);
        mon_en = 1'b0;
        chk("R2 no rest-level violations overall", cs_err, 0);

        report();
        $finish;
    end

endmodule